// File: doc/BRIEF.md
# Enhanced Configuration Bit Write Lock

This block keeps five 8-bit control registers for a serial port channel: interrupt enable, interrupt status, FIFO control, modem control and a feature register. Some fields in the first four registers are enhanced configuration fields. A single enable bit in the feature register guards them. While the enable bit is 1 (the OPEN state), software may change every bit. While it is 0 (the LOCKED state), writes still reach the ordinary bits, but the enhanced fields keep their stored values. Older driver code that writes whole bytes therefore cannot disturb an enhanced setup once it has been locked.

Register writes come in as an address, a data byte and a one-cycle strobe. All register values are driven on output ports every cycle. A combinational read port also returns the register selected by a read address. The address map is 0 = interrupt enable, 1 = interrupt status, 2 = FIFO control, 3 = modem control, 4 = feature. Addresses 5 to 7 are not decoded.

The lock controller is a two-state machine with states ST_LOCKED (the reset state) and ST_OPEN. It has two transitions. T_UNLOCK goes from ST_LOCKED to ST_OPEN on a feature-register write with bit 4 set to 1. T_LOCK goes from ST_OPEN to ST_LOCKED on a feature-register write with bit 4 cleared to 0. Every other cycle keeps the present state.

Top module: `enh_lock_top`

## Requirements
- R1: After reset, all five registers read 0x00 and `enh_open` is 0 (ST_LOCKED).
- R2: The guarded fields are interrupt-enable bits 7:4, status bits 5:4, FIFO-control bits 5:4 and modem-control bits 7:5. In ST_OPEN, a write sets all 8 bits of the addressed register to the write data on the next clock edge.
- R3: In ST_LOCKED, a write leaves the guarded bits of the addressed register unchanged.
- R4: In ST_LOCKED, a write still sets the unguarded bits of the addressed register to the write data.
- R5: A feature-register write stores all 8 data bits in any state. Its bit 4 sets `enh_open` on the next clock edge (1 = ST_OPEN, 0 = ST_LOCKED). From the next cycle on, guarded-field writes follow the new state, including a write in the very next cycle.
- R6: A write to address 5, 6 or 7 changes no register and no state. A cycle with no write strobe changes nothing.
- R7: `rd_data` equals the register at `rd_addr` in the same cycle. Addresses 5 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Selected register value |
| ier_q | output | 8 | Interrupt enable register |
| isr_q | output | 8 | Interrupt status register |
| fcr_q | output | 8 | FIFO control register |
| mcr_q | output | 8 | Modem control register |
| feat_q | output | 8 | Feature register |
| enh_open | output | 1 | 1 when the enhanced fields are open to writes |

## Verification
The hardest case is the boundary right after a state change. The bench writes the feature register and then writes a guarded register in the very next cycle. This checks that the new state governs that write and that the old state does not leak into it. The stimulus covers both directions: an unlock followed at once by a full-byte write, and a relock followed at once by a write of the opposite pattern. In each case both the guarded and the unguarded bits are compared with a model built from the requirements.

// File: rtl/enhlock_pkg.sv
package enhlock_pkg;
    localparam int DW   = 8;
    localparam int AW   = 3;
    localparam int NREG = 5;
    localparam int ENA_BIT = 4;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_e;

    localparam logic [AW-1:0] A_IER  = 3'd0;
    localparam logic [AW-1:0] A_ISR  = 3'd1;
    localparam logic [AW-1:0] A_FCR  = 3'd2;
    localparam logic [AW-1:0] A_MCR  = 3'd3;
    localparam logic [AW-1:0] A_FEAT = 3'd4;

    // guarded-field masks, indexed by register address
    localparam logic [DW-1:0] GUARD [NREG] = '{8'hF0, 8'h30, 8'h30, 8'hE0, 8'h00};
endpackage

// File: rtl/enh_reg_slice.sv
module enh_reg_slice
    import enhlock_pkg::*;
#(
    parameter logic [AW-1:0] ADDR  = '0,
    parameter logic [DW-1:0] GMASK = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          open,
    output logic [DW-1:0] q
);
    logic          hit;
    logic [DW-1:0] keep;
    logic [DW-1:0] nxt;

    always_comb begin
        hit  = wr_en && (wr_addr == ADDR);
        keep = open ? '0 : GMASK;
        nxt  = (q & keep) | (wr_data & ~keep);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= nxt;
    end
endmodule

// File: rtl/enh_lock_fsm.sv
module enh_lock_fsm
    import enhlock_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          ena_bit,
    output logic          open
);
    lock_state_e state, state_nxt;
    logic feat_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nxt;
    end

    always_comb begin
        feat_wr   = wr_en && (wr_addr == A_FEAT);
        state_nxt = state;
        unique case (state)
            ST_LOCKED: if (feat_wr && ena_bit)  state_nxt = ST_OPEN;   // T_UNLOCK
            ST_OPEN:   if (feat_wr && !ena_bit) state_nxt = ST_LOCKED; // T_LOCK
            default:   state_nxt = ST_LOCKED;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_OPEN: open = 1'b1;
            default: open = 1'b0;
        endcase
    end
endmodule

// File: rtl/enh_lock_top.sv
module enh_lock_top
    import enhlock_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] ier_q,
    output logic [DW-1:0] isr_q,
    output logic [DW-1:0] fcr_q,
    output logic [DW-1:0] mcr_q,
    output logic [DW-1:0] feat_q,
    output logic          enh_open
);
    logic [DW-1:0] regs [NREG];
    logic          open;

    enh_lock_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .ena_bit (wr_data[ENA_BIT]),
        .open    (open)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        enh_reg_slice #(
            .ADDR  (AW'(g)),
            .GMASK (GUARD[g])
        ) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .open    (open),
            .q       (regs[g])
        );
    end

    always_comb begin
        ier_q    = regs[A_IER];
        isr_q    = regs[A_ISR];
        fcr_q    = regs[A_FCR];
        mcr_q    = regs[A_MCR];
        feat_q   = regs[A_FEAT];
        enh_open = open;
        unique case (rd_addr)
            A_IER:   rd_data = regs[A_IER];
            A_ISR:   rd_data = regs[A_ISR];
            A_FCR:   rd_data = regs[A_FCR];
            A_MCR:   rd_data = regs[A_MCR];
            A_FEAT:  rd_data = regs[A_FEAT];
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/enhlock_chk.sv
module enhlock_chk
    import enhlock_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] ier_q,
    input logic [DW-1:0] isr_q,
    input logic [DW-1:0] fcr_q,
    input logic [DW-1:0] mcr_q,
    input logic [DW-1:0] feat_q,
    input logic          enh_open
);
    // R3
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_open && wr_en && wr_addr == A_IER) |=> ier_q[7:4] == $past(ier_q[7:4]));
    // R4
    p_unguarded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_open && wr_en && wr_addr == A_MCR) |=> mcr_q[4:0] == $past(wr_data[4:0]));
    // R2
    p_open_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_open && wr_en && wr_addr == A_FCR) |=> fcr_q == $past(wr_data));
    // R5
    p_feat_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FEAT) |=> (enh_open == $past(wr_data[ENA_BIT]) && feat_q == $past(wr_data)));
    // R6
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(isr_q) && $stable(enh_open) && $stable(ier_q)));
    // R7
    p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_MCR) |-> rd_data == mcr_q);
endmodule

bind enh_lock_top enhlock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ier_q(ier_q), .isr_q(isr_q),
    .fcr_q(fcr_q), .mcr_q(mcr_q), .feat_q(feat_q), .enh_open(enh_open)
);

// File: tb/tb_enh_lock_top.sv
module tb_enh_lock_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data, ier_q, isr_q, fcr_q, mcr_q, feat_q;
    logic       enh_open;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m [5];
    logic       m_open;
    bit         done = 0;

    always #10 clk = ~clk; // 50 MHz

    enh_lock_top dut (.*);

    function automatic logic [7:0] gmask(input int a);
        case (a)
            0: return 8'hF0;
            1: return 8'h30;
            2: return 8'h30;
            3: return 8'hE0;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // drive at negedge, captured at following posedge, visible at next negedge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (a < 5) begin
            logic [7:0] k;
            k = m_open ? 8'h00 : gmask(a);
            m[a] = (m[a] & k) | (d & ~k);
            if (a == 4) m_open = d[4];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " ier"}, ier_q, m[0]);
        chk({tag, " isr"}, isr_q, m[1]);
        chk({tag, " fcr"}, fcr_q, m[2]);
        chk({tag, " mcr"}, mcr_q, m[3]);
        chk({tag, " feat"}, feat_q, m[4]);
        chk({tag, " open"}, {7'd0, enh_open}, {7'd0, m_open});
    endtask

    task automatic t_reset;
        for (int i = 0; i < 5; i++) m[i] = 8'h00;
        m_open = 1'b0;
        chk_all("R1 reset");
    endtask

    task automatic t_locked_legacy;
        for (int a = 0; a < 4; a++) wr(3'(a), 8'hFF);
        chk_all("R4 locked ones");
        chk("R3 ier guarded", ier_q & 8'hF0, 8'h00);
        chk("R4 mcr low", mcr_q, 8'h1F);
    endtask

    task automatic t_unlock_back_to_back;
        wr(3'd4, 8'h10);
        wr(3'd0, 8'hA5);   // very next cycle after unlock
        wr(3'd1, 8'h3C);
        wr(3'd2, 8'hF3);
        wr(3'd3, 8'hE1);
        chk_all("R5 R2 open writes");
        chk("R2 ier full", ier_q, 8'hA5);
    endtask

    task automatic t_relock_back_to_back;
        wr(3'd4, 8'h0B);   // lock, other bits stored
        wr(3'd0, 8'h5A);   // very next cycle after lock
        wr(3'd3, 8'h00);
        wr(3'd1, 8'hC0);
        wr(3'd2, 8'h0C);
        chk_all("R5 R3 relock");
        chk("R3 ier kept", ier_q, 8'hAA);
        chk("R3 mcr kept", mcr_q, 8'hE0);
        chk("R5 feat bits", feat_q, 8'h0B);
    endtask

    task automatic t_unused_and_idle;
        wr(3'd5, 8'h10);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        repeat (3) @(negedge clk);
        chk_all("R6 unused/idle");
    endtask

    task automatic t_feat_locked_other;
        wr(3'd4, 8'hEF);   // bit4 = 0: stays locked
        chk_all("R5 feat locked");
        wr(3'd4, 8'hFF);
        wr(3'd4, 8'hFF);   // open->open
        chk_all("R5 feat open hold");
    endtask

    task automatic t_readback;
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            chk("R7 readback", rd_data, (a < 5) ? m[a] : 8'h00);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_readback;
        t_locked_legacy;
        t_unlock_back_to_back;
        t_readback;
        t_relock_back_to_back;
        t_unused_and_idle;
        t_feat_locked_other;
        t_readback;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule